// File: doc/BRIEF.md
# Raster Display Timing Generator

This block turns a pixel clock into the control stream of a raster display: horizontal sync, vertical sync, data enable, the column and row of the active pixel, a gated pixel data path and a frame interrupt. Each axis walks through four intervals: active, front porch, sync, back porch. Software sets the length of each interval through a small write-only register port, and every length is stored as its value minus one. The pixel clock comes in from outside, and nothing here fetches or formats framebuffer data.

Software programs the eight interval lengths and the output levels, then sets the run bit. Scanning starts at the first active pixel of the first line. New interval lengths written while the raster runs are held back until the current frame has finished, so a frame is never split between two geometries. The interrupt marks the start of vertical sync. It is gated by an enable bit and cleared by a write.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset all outputs are low, x and y are zero, irq_o is low, the raster is stopped and all four polarity bits are 1.
- R2: While running, every line is H_ACT+1 active clocks, then H_FP+1 front porch clocks, then H_SYNC+1 sync clocks, then H_BP+1 back porch clocks. hsync is active only in the sync clocks.
- R3: Every frame is V_ACT+1 active lines, then V_FP+1, V_SYNC+1 and V_BP+1 lines in that order. vsync is active for the whole of each sync line.
- R4: Data enable is active only when both axes are in their active interval. x is the clock index within the active part of the line and is 0 elsewhere. y is the line index within the active part of the frame and is 0 elsewhere.
- R5: Polarity register (address 1): bit 0 hsync, bit 1 vsync, bit 2 data enable, bit 3 data. A 1 makes the signal active high. A 0 inverts it, including its idle level.
- R6: pix_o carries pix_in, registered, during data enable, and the all-zero word otherwise. Both cases are then subject to the data polarity bit.
- R7: Writing bit 0 of address 0 as 1 starts scanning, and the first active pixel appears on the second clock edge after the write. Writing 0 stops it. One edge later the outputs are at their idle levels with x = y = 0, and a later start again begins at the first active pixel.
- R8: An interrupt status bit is set at the first pixel of the first vsync line. irq_o is that status ANDed with bit 0 of address 2. The status persists while the enable is 0.
- R9: Writing 1 to bit 0 of address 3 clears the interrupt status.
- R10: Interval lengths live at addresses 4..7 (horizontal active, front porch, sync, back porch) and 8..11 (the same for vertical). A write made while running takes effect at the first pixel of the next frame. A write made while stopped is in force before any later start.
- R11: A vertical active value above MAX_LINES-1 is stored as MAX_LINES-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | REG_W | Register write data |
| pix_in | input | DATA_W | Pixel word for the current position |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| x_o | output | H_W | Active column |
| y_o | output | V_W | Active row |
| pix_o | output | DATA_W | Gated pixel data |
| irq_o | output | 1 | Vertical sync interrupt |

## Verification
The properties look at the active-high internal levels before the polarity stage, so they take for granted that the interval lengths change only while stopped or at a frame boundary. They also assume MAX_LINES fits in V_W bits. The stimulus writes geometry only while the raster is stopped, except for one horizontal write in the middle of a frame, which exercises the deferred load. The bench clamps the vertical active length through a small MAX_LINES, so row values stay inside the capped range.

// File: rtl/tg_pkg.sv
package tg_pkg;
    // interval order along an axis; the address decode relies on it
    typedef enum logic [1:0] {
        PH_ACT  = 2'd0,
        PH_FP   = 2'd1,
        PH_SYNC = 2'd2,
        PH_BP   = 2'd3
    } tg_phase_e;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_RUN     = 4'd0;
    localparam logic [ADDR_W-1:0] A_POL     = 4'd1;
    localparam logic [ADDR_W-1:0] A_IRQ_EN  = 4'd2;
    localparam logic [ADDR_W-1:0] A_IRQ_CLR = 4'd3;
    localparam logic [ADDR_W-1:0] A_H_ACT   = 4'd4;
    localparam logic [ADDR_W-1:0] A_H_FP    = 4'd5;
    localparam logic [ADDR_W-1:0] A_H_SYNC  = 4'd6;
    localparam logic [ADDR_W-1:0] A_H_BP    = 4'd7;
    localparam logic [ADDR_W-1:0] A_V_ACT   = 4'd8;
    localparam logic [ADDR_W-1:0] A_V_FP    = 4'd9;
    localparam logic [ADDR_W-1:0] A_V_SYNC  = 4'd10;
    localparam logic [ADDR_W-1:0] A_V_BP    = 4'd11;

    localparam int POL_HS  = 0;
    localparam int POL_VS  = 1;
    localparam int POL_DE  = 2;
    localparam int POL_DAT = 3;
endpackage

// File: rtl/tg_regs.sv
module tg_regs import tg_pkg::*; #(
    parameter int H_W       = 12,
    parameter int V_W       = 12,
    parameter int REG_W     = 16,
    parameter int MAX_LINES = 2048
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [REG_W-1:0]      wr_data,
    input  logic                  load,
    output logic                  run_o,
    output logic [3:0]            pol_o,
    output logic                  irq_en_o,
    output logic                  irq_clr_o,
    output logic [3:0][H_W-1:0]   h_len_o,
    output logic [3:0][V_W-1:0]   v_len_o
);
    localparam logic [REG_W-1:0] V_CAP_W = REG_W'(MAX_LINES - 1);
    localparam logic [V_W-1:0]   V_CAP   = V_W'(MAX_LINES - 1);

    typedef struct packed {
        logic                run;
        logic [3:0]          pol;
        logic                en;
        logic [3:0][H_W-1:0] h_pend;
        logic [3:0][H_W-1:0] h_cur;
        logic [3:0][V_W-1:0] v_pend;
        logic [3:0][V_W-1:0] v_cur;
    } regs_t;

    regs_t d, q;
    logic [V_W-1:0] v_val;

    always_comb begin
        d         = q;
        irq_clr_o = wr_en && (wr_addr == A_IRQ_CLR) && wr_data[0];
        v_val     = wr_data[V_W-1:0];
        if ((wr_addr == A_V_ACT) && (wr_data > V_CAP_W)) begin
            v_val = V_CAP;
        end
        if (wr_en) begin
            case (wr_addr)
                A_RUN:    d.run = wr_data[0];
                A_POL:    d.pol = wr_data[3:0];
                A_IRQ_EN: d.en  = wr_data[0];
                A_H_ACT, A_H_FP, A_H_SYNC, A_H_BP:
                    d.h_pend[wr_addr[1:0]] = wr_data[H_W-1:0];
                A_V_ACT, A_V_FP, A_V_SYNC, A_V_BP:
                    d.v_pend[wr_addr[1:0]] = v_val;
                default: ;
            endcase
        end
        if (load) begin
            d.h_cur = q.h_pend;
            d.v_cur = q.v_pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.pol <= 4'b1111;
        end else begin
            q <= d;
        end
    end

    assign run_o    = q.run;
    assign pol_o    = q.pol;
    assign irq_en_o = q.en;
    assign h_len_o  = q.h_cur;
    assign v_len_o  = q.v_cur;
endmodule

// File: rtl/tg_axis.sv
module tg_axis import tg_pkg::*; #(
    parameter int W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic [3:0][W-1:0] len,
    output tg_phase_e        phase_o,
    output logic [W-1:0]     cnt_o,
    output logic             last_o
);
    typedef struct packed {
        tg_phase_e    ph;
        logic [W-1:0] cnt;
    } axis_t;

    axis_t d, q;
    logic [W-1:0] lim;
    tg_phase_e    nxt_ph;

    always_comb begin
        lim = len[q.ph];
        case (q.ph)
            PH_ACT:  nxt_ph = PH_FP;
            PH_FP:   nxt_ph = PH_SYNC;
            PH_SYNC: nxt_ph = PH_BP;
            default: nxt_ph = PH_ACT;
        endcase
        last_o = (q.ph == PH_BP) && (q.cnt == lim);
        d = q;
        if (clear) begin
            d.ph  = PH_ACT;
            d.cnt = '0;
        end else if (step) begin
            if (q.cnt == lim) begin
                d.ph  = nxt_ph;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.ph  <= PH_ACT;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign phase_o = q.ph;
    assign cnt_o   = q.cnt;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen import tg_pkg::*; #(
    parameter int H_W       = 12,
    parameter int V_W       = 12,
    parameter int REG_W     = 16,
    parameter int DATA_W    = 24,
    parameter int MAX_LINES = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic [DATA_W-1:0] pix_in,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [H_W-1:0]    x_o,
    output logic [V_W-1:0]    y_o,
    output logic [DATA_W-1:0] pix_o,
    output logic              irq_o
);
    localparam int N_CTL = 3;

    logic                run, irq_en, irq_clr, frame_end;
    logic [3:0]          pol;
    logic [3:0][H_W-1:0] h_len;
    logic [3:0][V_W-1:0] v_len;
    tg_phase_e           h_ph, v_ph;
    logic [H_W-1:0]      h_cnt;
    logic [V_W-1:0]      v_cnt;
    logic                h_last, v_last;

    assign frame_end = run & h_last & v_last;

    tg_regs #(
        .H_W(H_W), .V_W(V_W), .REG_W(REG_W), .MAX_LINES(MAX_LINES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load(~run | frame_end),
        .run_o(run), .pol_o(pol), .irq_en_o(irq_en), .irq_clr_o(irq_clr),
        .h_len_o(h_len), .v_len_o(v_len)
    );

    tg_axis #(.W(H_W)) u_hax (
        .clk(clk), .rst_n(rst_n), .clear(~run), .step(run),
        .len(h_len), .phase_o(h_ph), .cnt_o(h_cnt), .last_o(h_last)
    );

    tg_axis #(.W(V_W)) u_vax (
        .clk(clk), .rst_n(rst_n), .clear(~run), .step(run & h_last),
        .len(v_len), .phase_o(v_ph), .cnt_o(v_cnt), .last_o(v_last)
    );

    typedef struct packed {
        logic              hs;
        logic              vs;
        logic              de;
        logic              st;
        logic [H_W-1:0]    x;
        logic [V_W-1:0]    y;
        logic [DATA_W-1:0] pix;
    } out_t;

    out_t out_d, out_q;
    logic vs_start;

    always_comb begin
        vs_start = run && (v_ph == PH_SYNC) && (v_cnt == '0)
                       && (h_ph == PH_ACT) && (h_cnt == '0);
        out_d.hs  = run && (h_ph == PH_SYNC);
        out_d.vs  = run && (v_ph == PH_SYNC);
        out_d.de  = run && (h_ph == PH_ACT) && (v_ph == PH_ACT);
        out_d.x   = (run && (h_ph == PH_ACT)) ? h_cnt : '0;
        out_d.y   = (run && (v_ph == PH_ACT)) ? v_cnt : '0;
        out_d.pix = out_d.de ? pix_in : '0;
        out_d.st  = vs_start | (out_q.st & ~irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    // active-high internal levels, observed by the checker
    logic hs_a, vs_a, de_a, st_q;
    assign hs_a = out_q.hs;
    assign vs_a = out_q.vs;
    assign de_a = out_q.de;
    assign st_q = out_q.st;

    logic [N_CTL-1:0] ctl_act, ctl_pin;
    assign ctl_act = {de_a, vs_a, hs_a};

    for (genvar i = 0; i < N_CTL; i++) begin : g_pol
        assign ctl_pin[i] = pol[i] ? ctl_act[i] : ~ctl_act[i];
    end

    assign hsync_o = ctl_pin[POL_HS];
    assign vsync_o = ctl_pin[POL_VS];
    assign de_o    = ctl_pin[POL_DE];
    assign pix_o   = pol[POL_DAT] ? out_q.pix : ~out_q.pix;
    assign x_o     = out_q.x;
    assign y_o     = out_q.y;
    assign irq_o   = st_q & irq_en;
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
    parameter int H_W       = 12,
    parameter int V_W       = 12,
    parameter int MAX_LINES = 2048
) (
    input logic           clk,
    input logic           rst_n,
    input logic           run,
    input logic           hs_a,
    input logic           vs_a,
    input logic           de_a,
    input logic           st,
    input logic [H_W-1:0] x,
    input logic [V_W-1:0] y
);
    localparam logic [V_W-1:0] Y_MAX = V_W'(MAX_LINES - 1);

    p_idle_when_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!de_a && !hs_a && !vs_a && x == '0 && y == '0))
        else $error("stopped raster produced activity");

    p_de_outside_sync_r4: assert property (@(posedge clk) disable iff (!rst_n)
        de_a |-> (!hs_a && !vs_a))
        else $error("data enable overlaps a sync interval");

    p_x_advances_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (de_a && $past(de_a)) |-> (x == $past(x) + 1'b1))
        else $error("column did not advance by one");

    p_irq_on_vs_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st) |-> $rose(vs_a))
        else $error("interrupt status set away from vsync start");

    p_y_capped_r11: assert property (@(posedge clk) disable iff (!rst_n)
        y <= Y_MAX)
        else $error("row beyond line cap");
endmodule

bind raster_timing_gen tg_checker #(
    .H_W(H_W), .V_W(V_W), .MAX_LINES(MAX_LINES)
) u_tg_chk (
    .clk(clk), .rst_n(rst_n), .run(run),
    .hs_a(hs_a), .vs_a(vs_a), .de_a(de_a), .st(st_q),
    .x(x_o), .y(y_o)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
    localparam int H_W = 12;
    localparam int V_W = 12;
    localparam int REG_W = 16;
    localparam int DATA_W = 24;
    localparam int MAX_LINES = 5;
    localparam time PERIOD = 20ns;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [3:0]        wr_addr = '0;
    logic [REG_W-1:0]  wr_data = '0;
    logic [DATA_W-1:0] pix_in = '0;
    logic              hsync_o, vsync_o, de_o, irq_o;
    logic [H_W-1:0]    x_o;
    logic [V_W-1:0]    y_o;
    logic [DATA_W-1:0] pix_o;

    always #(PERIOD/2) clk = ~clk;

    raster_timing_gen #(
        .H_W(H_W), .V_W(V_W), .REG_W(REG_W), .DATA_W(DATA_W), .MAX_LINES(MAX_LINES)
    ) i_raster_timing_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pix_in(pix_in), .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .x_o(x_o), .y_o(y_o), .pix_o(pix_o), .irq_o(irq_o)
    );

    typedef struct packed {
        logic              hs;
        logic              vs;
        logic              de;
        logic              irq;
        logic [H_W-1:0]    x;
        logic [V_W-1:0]    y;
        logic [DATA_W-1:0] pix;
    } item_t;

    item_t exp_q[$];
    int    n_chk = 0;
    int    n_bad = 0;
    logic  exp_st = 1'b0;
    bit    done = 1'b0;

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [REG_W-1:0] dat);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R10: addresses 4..7 horizontal, 8..11 vertical, value = length - 1
    task automatic setup(input int hl[4], input int vl[4]);
        for (int i = 0; i < 4; i++) wr(4'(4 + i), REG_W'(hl[i] - 1));
        for (int i = 0; i < 4; i++) wr(4'(8 + i), REG_W'(vl[i] - 1));
    endtask

    // driver: expected stream from the interval rules
    task automatic push_frames(input int hl[4], input int vl[4], input int nfr,
                               input logic [3:0] pol, input logic [DATA_W-1:0] pin, input logic en);
        int ht, vt;
        ht = hl[0] + hl[1] + hl[2] + hl[3];
        vt = vl[0] + vl[1] + vl[2] + vl[3];
        for (int f = 0; f < nfr; f++)
            for (int v = 0; v < vt; v++)
                for (int h = 0; h < ht; h++) begin
                    item_t it;
                    logic  hsa, vsa, dea;
                    hsa = (h >= hl[0] + hl[1]) && (h < hl[0] + hl[1] + hl[2]);
                    vsa = (v >= vl[0] + vl[1]) && (v < vl[0] + vl[1] + vl[2]);
                    dea = (h < hl[0]) && (v < vl[0]);
                    if (v == vl[0] + vl[1] && h == 0) exp_st = 1'b1;
                    it.hs  = pol[0] ? hsa : ~hsa;
                    it.vs  = pol[1] ? vsa : ~vsa;
                    it.de  = pol[2] ? dea : ~dea;
                    it.x   = (h < hl[0]) ? H_W'(h) : '0;
                    it.y   = (v < vl[0]) ? V_W'(v) : '0;
                    it.pix = dea ? pin : '0;
                    if (!pol[3]) it.pix = ~it.pix;
                    it.irq = exp_st & en;
                    exp_q.push_back(it);
                end
    endtask

    // monitor: one compare per clock, sampled at the falling edge
    task automatic drain(input string req);
        while (exp_q.size() > 0) begin
            item_t e, a;
            @(negedge clk);
            e = exp_q.pop_front();
            a = '{hs: hsync_o, vs: vsync_o, de: de_o, irq: irq_o,
                  x: x_o, y: y_o, pix: pix_o};
            chk(a == e, req, 64'(a), 64'(e));
        end
    endtask

    task automatic check_idle(input logic [3:0] pol, input string req);
        item_t e, a;
        @(negedge clk);
        e = '{hs: ~pol[0], vs: ~pol[1], de: ~pol[2], irq: 1'b0,
              x: '0, y: '0, pix: pol[3] ? '0 : '1};
        a = '{hs: hsync_o, vs: vsync_o, de: de_o, irq: 1'b0,
              x: x_o, y: y_o, pix: pix_o};
        chk(a == e, req, 64'(a), 64'(e));
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int ha[4], va[4], hb[4], vb[4], hw[4], vc[4];
        ha = '{4, 2, 3, 2}; va = '{3, 1, 2, 1};
        hb = '{3, 1, 1, 1}; vb = '{2, 1, 1, 1};
        hw = '{6, 2, 3, 2}; vc = '{5, 1, 2, 1};

        repeat (3) @(negedge clk);
        // R1: reset state
        chk({hsync_o, vsync_o, de_o, irq_o} == 4'b0000, "R1 controls", 64'({hsync_o, vsync_o, de_o, irq_o}), 64'd0);
        chk(x_o == '0 && y_o == '0 && pix_o == '0, "R1 data", 64'({x_o, y_o}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 R3 R4 R6 R8: two frames, active-high, interrupt enabled
        setup(ha, va);
        wr(tg_pkg::A_POL, 16'hF);
        wr(tg_pkg::A_IRQ_EN, 16'h1);
        pix_in = 24'hA5C3E1;
        exp_st = 1'b0;
        push_frames(ha, va, 2, 4'hF, pix_in, 1'b1);
        wr(tg_pkg::A_RUN, 16'h1);
        drain("R2/R3/R4/R6/R8 frame A");
        wr(tg_pkg::A_RUN, 16'h0);
        check_idle(4'hF, "R7 stop idle");

        // R5: all polarity bits inverted, shortest porches, interrupt masked
        wr(tg_pkg::A_IRQ_CLR, 16'h1);
        exp_st = 1'b0;
        setup(hb, vb);
        wr(tg_pkg::A_POL, 16'h0);
        wr(tg_pkg::A_IRQ_EN, 16'h0);
        pix_in = 24'h3C0F81;
        check_idle(4'h0, "R5 inverted idle");
        push_frames(hb, vb, 2, 4'h0, pix_in, 1'b0);
        wr(tg_pkg::A_RUN, 16'h1);
        drain("R5/R2/R3/R8 frame B masked");
        wr(tg_pkg::A_RUN, 16'h0);
        check_idle(4'h0, "R7 stop idle inverted");

        // R8: status kept while masked, R9: clear
        wr(tg_pkg::A_IRQ_EN, 16'h1);
        chk(irq_o == 1'b1, "R8 pending after unmask", 64'(irq_o), 64'd1);
        wr(tg_pkg::A_IRQ_CLR, 16'h1);
        chk(irq_o == 1'b0, "R9 clear", 64'(irq_o), 64'd0);
        exp_st = 1'b0;

        // R10: horizontal active rewritten mid-frame applies to the next frame
        wr(tg_pkg::A_POL, 16'hF);
        setup(ha, va);
        pix_in = 24'h00FF5A;
        push_frames(ha, va, 1, 4'hF, pix_in, 1'b1);
        push_frames(hw, va, 1, 4'hF, pix_in, 1'b1);
        wr(tg_pkg::A_RUN, 16'h1);
        fork
            drain("R10 deferred load");
            begin
                repeat (20) @(negedge clk);
                wr(tg_pkg::A_H_ACT, 16'd5);
            end
        join
        wr(tg_pkg::A_RUN, 16'h0);
        check_idle(4'hF, "R7 stop after R10");

        // R11: vertical active above the cap (MAX_LINES=5) stored as 4
        wr(tg_pkg::A_IRQ_CLR, 16'h1);
        exp_st = 1'b0;
        wr(tg_pkg::A_V_ACT, 16'd9);
        wr(tg_pkg::A_V_FP, 16'd0);
        wr(tg_pkg::A_V_SYNC, 16'd1);
        wr(tg_pkg::A_V_BP, 16'd0);
        push_frames(hw, vc, 1, 4'hF, pix_in, 1'b1);
        wr(tg_pkg::A_RUN, 16'h1);
        drain("R11 capped lines, R7 restart");
        wr(tg_pkg::A_RUN, 16'h0);
        check_idle(4'hF, "R7 final stop");

        summary();
        $finish;
    end
endmodule